// File: doc/BRIEF.md
# Scaled Shift-and-Add Integer Unit

This execution unit sits in a 64-bit integer pipeline. It forms `base + (index << (scale + 1))`, so the index operand is always multiplied by 2, 4, 8 or 16 and never by 1. Hot loops use this to compute array addresses and scaled sums in one operation. The sum wraps modulo 2^64. Bits shifted out of the top and any carry out of the most significant bit are dropped, and no carry or overflow flag is produced.

An operation select picks how the index operand is formed:
- The full form uses the whole 64-bit index.
- The signed-word form uses the low 32 bits of the index, sign-extended.
- The unsigned-word form uses the low 32 bits, zero-extended. It suits base-plus-offset address generation.

A record request also produces a 4-bit condition field. The field holds the sign of the result compared against zero, plus a summary-overflow bit copied from an input.

The result, the condition field and its write enable all come out one clock after the issuing strobe. An operation select with the reserved code produces no result and pulses an illegal-operation flag instead.

Top module: `scaled_add_unit`

## Requirements
- R1: The shift applied to the extended index equals `in_scale + 1`: scale codes 0, 1, 2 and 3 multiply by 2, 4, 8 and 16.
- R2: With `in_op` = 2'b00 (full form), `out_result` = (`in_base` + (`in_index` << (`in_scale`+1))) mod 2^64, with operands unsigned.
- R3: With `in_op` = 2'b01 (signed-word form), the index is `in_index[31:0]` sign-extended to 64 bits before the shift; the upper 32 index bits have no effect.
- R4: With `in_op` = 2'b10 (unsigned-word form), the index is `in_index[31:0]` zero-extended to 64 bits before the shift; the upper 32 index bits have no effect.
- R5: `in_valid` high with a legal `in_op` in cycle N gives `out_valid` high and the result on `out_result` in cycle N+1. Without `in_valid`, `out_valid` is low the next cycle and `out_result` holds its value.
- R6: When `in_record` is high on a legal issue, `out_cr_we` is high with the result. The field is `out_cr` = {LT, GT, EQ, SO}, bits 3 down to 0. LT, GT and EQ come from a signed compare of the 64-bit result with zero, and exactly one of them is set. SO equals `in_so`.
- R7: When `in_record` is low on an issue, `out_cr_we` stays low and `out_cr` keeps its previous value.
- R8: `in_op` = 2'b11 with `in_valid` gives `out_illegal` high for exactly one cycle. In that cycle `out_valid` and `out_cr_we` are low, and `out_result` is unchanged.
- R9: A synchronous active-low reset clears `out_valid`, `out_illegal`, `out_cr_we`, `out_cr` and `out_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 2 | Operation select: 00 full, 01 signed word, 10 unsigned word, 11 reserved |
| in_scale | input | 2 | Scale code; shift is code plus one |
| in_record | input | 1 | Request a condition field |
| in_so | input | 1 | Summary-overflow value copied into the condition field |
| in_base | input | 64 | Addend operand |
| in_index | input | 64 | Operand that is extended and shifted |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered sum |
| out_cr_we | output | 1 | Condition field write enable |
| out_cr | output | 4 | {LT, GT, EQ, SO} |
| out_illegal | output | 1 | One-cycle flag for a reserved operation select |

## Verification
The bench drives a low word of 0x80000000 through both word forms. A unit that extends the index the wrong way returns a sum that is off by 2^(33+scale) in the upper half. All-ones operands at every scale catch a unit that keeps the carry out or shifts by the scale code instead of code plus one, since wrapped sums and a multiply by 1 give distinct values there. Results of zero, negative and positive values, with each level of the summary-overflow input, catch a condition field built from an unsigned compare or with swapped bit order. Reserved-code issues placed after a known result catch a unit that overwrites the held result or lets `out_valid` through.

// File: rtl/sau_pkg.sv
// Shared types for the scaled shift-and-add unit.
// Assumes a two-bit operation select whose fourth code is reserved.
package sau_pkg;

    typedef enum logic [1:0] {
        OP_FULL  = 2'b00,
        OP_SWORD = 2'b01,
        OP_UWORD = 2'b10,
        OP_RSVD  = 2'b11
    } sau_op_e;

    // Bit positions inside the condition field
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

endpackage

// File: rtl/sau_operand_prep.sv
// Operand preparation: extends the index per operation select, then
// shifts left by scale+1. Every shift candidate is built in parallel and
// one is picked by the scale code.
// Assumes the reserved select is filtered by the caller (it is treated as full).
module sau_operand_prep
    import sau_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int HALF    = 32,
    parameter int SCALE_W = 2
) (
    input  logic [1:0]         op,
    input  logic [SCALE_W-1:0] scale,
    input  logic [XLEN-1:0]    index,
    output logic [XLEN-1:0]    scaled
);
    localparam int NSCALE = 1 << SCALE_W;
    localparam int UPPER  = XLEN - HALF;

    logic [XLEN-1:0] ext;
    logic [XLEN-1:0] cand [NSCALE];

    // Pick the index extension for the selected form
    always_comb begin
        unique case (sau_op_e'(op))
            OP_SWORD: ext = {{UPPER{index[HALF-1]}}, index[HALF-1:0]};
            OP_UWORD: ext = {{UPPER{1'b0}}, index[HALF-1:0]};
            default:  ext = index;
        endcase
    end

    // One fixed shift per scale code, shift = code + 1
    for (genvar k = 0; k < NSCALE; k++) begin : g_shift
        assign cand[k] = ext << (k + 1);
    end

    assign scaled = cand[scale];

endmodule

// File: rtl/sau_adder.sv
// Modular adder: sum of two operands, carry out discarded.
// Assumes wrap-around arithmetic is wanted; no flags are produced.
module sau_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum
);
    // Wrapping add
    assign sum = a + b;

endmodule

// File: rtl/sau_cond_gen.sv
// Condition field builder: signed compare of a value with zero plus a
// copied summary-overflow bit. Layout is {LT, GT, EQ, SO}.
// Assumes the value is two's complement.
module sau_cond_gen
    import sau_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  logic            so,
    output logic [3:0]      cr
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = value[XLEN-1];
    assign is_zero = (value == '0);

    // Assemble the four condition bits
    always_comb begin
        cr        = '0;
        cr[CR_LT] = is_neg;
        cr[CR_GT] = !is_neg && !is_zero;
        cr[CR_EQ] = is_zero;
        cr[CR_SO] = so;
    end

endmodule

// File: rtl/scaled_add_unit.sv
// Scaled shift-and-add execution unit: base + (extended index << (scale+1)),
// registered with one cycle of latency, optional condition field, and
// an illegal-operation pulse for the reserved select.
// Assumes the issuing stage presents operands with in_valid in the same cycle.
module scaled_add_unit
    import sau_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int HALF    = 32,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic               in_record,
    input  logic               in_so,
    input  logic [XLEN-1:0]    in_base,
    input  logic [XLEN-1:0]    in_index,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic               out_cr_we,
    output logic [3:0]         out_cr,
    output logic               out_illegal
);
    logic            op_legal;
    logic            issue;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] sum;
    logic [3:0]      cr_next;

    assign op_legal = (sau_op_e'(in_op) != OP_RSVD);
    assign issue    = in_valid && op_legal;

    sau_operand_prep #(.XLEN(XLEN), .HALF(HALF), .SCALE_W(SCALE_W)) u_prep (
        .op     (in_op),
        .scale  (in_scale),
        .index  (in_index),
        .scaled (scaled)
    );

    sau_adder #(.XLEN(XLEN)) u_add (
        .a   (in_base),
        .b   (scaled),
        .sum (sum)
    );

    sau_cond_gen #(.XLEN(XLEN)) u_cond (
        .value (sum),
        .so    (in_so),
        .cr    (cr_next)
    );

    // Output stage: capture result and condition on a legal issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_cr_we   <= 1'b0;
            out_cr      <= '0;
            out_result  <= '0;
        end else begin
            out_valid   <= issue;
            out_illegal <= in_valid && !op_legal;
            out_cr_we   <= issue && in_record;
            if (issue) begin
                out_result <= sum;
            end
            if (issue && in_record) begin
                out_cr <= cr_next;
            end
        end
    end

endmodule

// File: rtl/sau_checker.sv
// Property checker for scaled_add_unit, attached by bind.
// Assumes a synchronous active-low reset on rst_n.
module sau_checker #(
    parameter int XLEN    = 64,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_op,
    input logic [SCALE_W-1:0] in_scale,
    input logic               in_record,
    input logic               in_so,
    input logic [XLEN-1:0]    in_base,
    input logic [XLEN-1:0]    in_index,
    input logic               out_valid,
    input logic [XLEN-1:0]    out_result,
    input logic               out_cr_we,
    input logic [3:0]         out_cr,
    input logic               out_illegal
);
    logic [XLEN-1:0] full_expect;
    assign full_expect = in_base + (in_index << ({1'b0, in_scale} + 1'b1));

    logic [XLEN-1:0] full_expect_q;
    // Keep the full-form expectation of the previous cycle
    always_ff @(posedge clk) begin
        full_expect_q <= full_expect;
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b11) |=> out_valid);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    p_full_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00) |=> (out_result == full_expect_q));

    p_record_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b11 && in_record) |=> (out_cr_we && out_cr[0] == $past(in_so)));

    p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_we |-> ($countones(out_cr[3:1]) == 1 && out_cr[1] == (out_result == '0)));

    p_no_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_record) |=> (!out_cr_we && $stable(out_cr)));

    p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11) |=> (out_illegal && !out_valid && !out_cr_we && $stable(out_result)));

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_illegal && out_valid));

endmodule

bind scaled_add_unit sau_checker #(.XLEN(XLEN), .SCALE_W(SCALE_W)) u_sau_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_scale    (in_scale),
    .in_record   (in_record),
    .in_so       (in_so),
    .in_base     (in_base),
    .in_index    (in_index),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_cr_we   (out_cr_we),
    .out_cr      (out_cr),
    .out_illegal (out_illegal)
);

// File: tb/scaled_add_unit_tb.sv
// Directed bench for scaled_add_unit: one task per scenario.
module scaled_add_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [1:0]  in_scale;
    logic        in_record;
    logic        in_so;
    logic [63:0] in_base;
    logic [63:0] in_index;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_cr_we;
    logic [3:0]  out_cr;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    scaled_add_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_scale(in_scale), .in_record(in_record), .in_so(in_so),
        .in_base(in_base), .in_index(in_index), .out_valid(out_valid),
        .out_result(out_result), .out_cr_we(out_cr_we), .out_cr(out_cr),
        .out_illegal(out_illegal)
    );

    // Expected sum from the requirements
    function automatic logic [63:0] model(input logic [1:0] op, input logic [1:0] sc,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] e;
        if (op == 2'b01)      e = {{32{b[31]}}, b[31:0]};
        else if (op == 2'b10) e = {32'h0, b[31:0]};
        else                  e = b;
        return a + (e << (int'(sc) + 1));
    endfunction

    function automatic logic [3:0] cr_model(input logic [63:0] v, input logic so);
        logic lt, eq;
        lt = v[63];
        eq = (v == 64'h0);
        return {lt, !lt && !eq, eq, so};
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation at a falling edge; outputs are sampled one cycle later
    task automatic issue(input logic [1:0] op, input logic [1:0] sc, input logic rec,
                         input logic so, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_scale = sc; in_record = rec;
        in_so = so; in_base = a; in_index = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_and_check(input string req, input logic [1:0] op, input logic [1:0] sc,
                                 input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp;
        exp = model(op, sc, a, b);
        issue(op, sc, 1'b0, 1'b0, a, b);
        check(out_valid === 1'b1, {req, " valid"}, 64'(out_valid), 64'h1);
        check(out_result === exp, req, out_result, exp);
    endtask

    task automatic t_reset_r9;
        check(out_valid === 1'b0 && out_illegal === 1'b0 && out_cr_we === 1'b0,
              "R9 flags", {61'h0, out_valid, out_illegal, out_cr_we}, 64'h0);
        check(out_result === 64'h0, "R9 result", out_result, 64'h0);
        check(out_cr === 4'h0, "R9 cr", 64'(out_cr), 64'h0);
    endtask

    task automatic t_scales_r1;
        for (int s = 0; s < 4; s++) begin
            run_and_check("R1 scale", 2'b00, 2'(s), 64'h0, 64'h1);
            check(out_result === (64'h1 << (s + 1)), "R1 multiplier", out_result, 64'h1 << (s + 1));
        end
    endtask

    task automatic t_full_r2;
        run_and_check("R2 full basic", 2'b00, 2'd3, 64'h1000, 64'h0000_0001_0000_0003);
        for (int s = 0; s < 4; s++)
            run_and_check("R2 full all-ones wrap", 2'b00, 2'(s), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_and_check("R2 full top bits dropped", 2'b00, 2'd0, 64'h1, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_sword_r3;
        for (int s = 0; s < 4; s++)
            run_and_check("R3 sword 0x80000000", 2'b01, 2'(s), 64'h0000_0010_0000_0000, 64'h0000_0000_8000_0000);
        run_and_check("R3 sword upper ignored", 2'b01, 2'd1, 64'h100, 64'hDEAD_BEEF_0000_0005);
        run_and_check("R3 sword all-ones", 2'b01, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_uword_r4;
        for (int s = 0; s < 4; s++)
            run_and_check("R4 uword 0x80000000", 2'b10, 2'(s), 64'h0000_0010_0000_0000, 64'h0000_0000_8000_0000);
        run_and_check("R4 uword upper ignored", 2'b10, 2'd3, 64'h4000, 64'hFFFF_FFFF_0000_0002);
        run_and_check("R4 uword all-ones", 2'b10, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_latency_r5;
        logic [63:0] held;
        run_and_check("R5 issue", 2'b00, 2'd1, 64'h55, 64'h3);
        held = out_result;
        @(negedge clk);
        check(out_valid === 1'b0, "R5 valid drops", 64'(out_valid), 64'h0);
        check(out_result === held, "R5 result holds", out_result, held);
    endtask

    task automatic t_record_r6;
        logic [63:0] exp;
        logic [3:0]  ecr;
        // zero result, positive result, negative result, each SO level
        for (int k = 0; k < 6; k++) begin
            logic [63:0] a;
            logic so;
            a  = (k % 3 == 0) ? 64'hFFFF_FFFF_FFFF_FFFC : (k % 3 == 1) ? 64'h7 : 64'h8000_0000_0000_0000;
            so = (k >= 3);
            exp = model(2'b00, 2'd1, a, 64'h1);
            ecr = cr_model(exp, so);
            issue(2'b00, 2'd1, 1'b1, so, a, 64'h1);
            check(out_cr_we === 1'b1, "R6 cr write enable", 64'(out_cr_we), 64'h1);
            check(out_cr === ecr, "R6 cr field", 64'(out_cr), 64'(ecr));
        end
    endtask

    task automatic t_norecord_r7;
        logic [3:0] prev;
        prev = out_cr;
        issue(2'b01, 2'd0, 1'b0, 1'b1, 64'h0, 64'h0);
        check(out_cr_we === 1'b0, "R7 cr write enable low", 64'(out_cr_we), 64'h0);
        check(out_cr === prev, "R7 cr unchanged", 64'(out_cr), 64'(prev));
    endtask

    task automatic t_illegal_r8;
        logic [63:0] held;
        run_and_check("R8 setup", 2'b10, 2'd2, 64'h1234, 64'h10);
        held = out_result;
        issue(2'b11, 2'd3, 1'b1, 1'b0, 64'hAAAA, 64'hBBBB);
        check(out_illegal === 1'b1, "R8 illegal flag", 64'(out_illegal), 64'h1);
        check(out_valid === 1'b0 && out_cr_we === 1'b0, "R8 no valid",
              {62'h0, out_valid, out_cr_we}, 64'h0);
        check(out_result === held, "R8 result held", out_result, held);
        @(negedge clk);
        check(out_illegal === 1'b0, "R8 one cycle", 64'(out_illegal), 64'h0);
    endtask

    task automatic t_mixed;
        for (int i = 0; i < 40; i++) begin
            logic [1:0] op;
            op = 2'(i % 3);
            run_and_check(op == 2'b00 ? "R2 mixed" : op == 2'b01 ? "R3 mixed" : "R4 mixed",
                          op, 2'(i % 4), {$urandom, $urandom}, {$urandom, $urandom});
        end
    endtask

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_scale = 2'b00;
        in_record = 1'b0; in_so = 1'b0; in_base = '0; in_index = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r9;
        t_scales_r1;
        t_full_r2;
        t_sword_r3;
        t_uword_r4;
        t_latency_r5;
        t_record_r6;
        t_norecord_r7;
        t_illegal_r8;
        t_mixed;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule